// File: doc/BRIEF.md
# Programmable reference clock generator

This block produces a reference clock from one base clock that an external glitch-free multiplexer has already chosen. Software programs a single 32-bit control word over a plain write-enable/read-enable port: an enable, a 15-bit half-period divisor, a 4-bit source code that goes out to the external multiplexer, a pin-drive enable and three power-mode qualifiers (debug freeze, idle stop, run in standby sleep). A divisor N of 1 or more makes the output stay high for N base cycles and low for N base cycles. N equal to zero passes the base clock through.

The control word lives in the bus clock domain. The enable and a divisor-switch request cross into the base clock domain through two-flop synchronisers. A status flag that shows the clock request is live, and a done flag for the divisor switch, cross back the same way. In the base domain a four-state machine runs the divider. In ST_OFF the counter is cleared and the working divisor follows the register. Synchronised ON moves it ST_OFF→ST_RUN. From any running state, freeze (FRZ and debug) moves it →ST_HOLD. Otherwise, idle or sleep gating moves it →ST_STOP. Otherwise it goes →ST_RUN. Loss of ON moves every state →ST_OFF. ST_HOLD keeps the counter and output unchanged. ST_STOP forces the output low and clears the counter.

Top module: `rc_refgen`

## Requirements
- R1: Control word layout: divisor at bits 30:16, ON 15, FRZ 14, SIDL 13, OE 12, RSLP 11, switch-busy 9, ACTIVE 8, source code 3:0. All other bits read 0. Reset clears the word to 0.
- R2: With divisor N ≥ 1 and the divider running, the output is high for exactly N base cycles and then low for exactly N base cycles.
- R3: With divisor 0 and the divider running, the output equals the base clock.
- R4: ACTIVE (bit 8) is read-only. Writing it has no effect. It rises only after ON has been written to 1, within a few cycles given by the synchronisers.
- R5: Writing 1 to bit 9 while running requests a new divisor. Bit 9 reads 1 until hardware has loaded the divisor and then clears by itself. The load happens only at a half-period boundary, so every high or low phase lasts either the old or the new N.
- R6: With FRZ=1 and debug asserted, the counter and output hold their value. With FRZ=0, debug has no effect.
- R7: With SIDL=1 and idle asserted, the output stops low. With SIDL=0, idle has no effect.
- R8: In standby sleep the output stops low when RSLP=0 or the source code is 0000 or 0001. It keeps running only when RSLP=1 and the code is 0010 or above.
- R9: The pin output is 0 whenever OE=0 and equals the reference clock when OE=1.
- R10: A write to the source field is ignored while ACTIVE=1. The stored code is driven on `sel_o`.
- R11: Any write made while ON differs from ACTIVE leaves the whole control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| wr_en | input | 1 | Write strobe for the control word |
| rd_en | input | 1 | Read strobe; rdata is 0 when low |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (control word with status) |
| base_clk | input | 1 | Selected base clock to divide |
| base_rst_n | input | 1 | Active-low reset, base domain |
| dbg_i | input | 1 | Debug mode active |
| idle_i | input | 1 | Idle mode active |
| sleep_i | input | 1 | Standby sleep active |
| ref_clk_o | output | 1 | Reference clock output |
| ref_pin_o | output | 1 | Pin drive, gated by OE |
| sel_o | output | 4 | Source code to the external multiplexer |

## Verification
The hardest case to reach from the ports is a divisor change while the divider is running. Software has to issue the request through the busy bit while ON and ACTIVE agree, and the load must then land on a phase boundary. The bench starts the divider at 2, writes 3 with the switch bit set, and records every high and low run length around the change. It expects each complete run to last 2 or 3 cycles, the last ones to last 3, and the busy bit to have cleared. The sleep rule depends on both RSLP and the source code, so a table walks the code values in both RSLP settings, bringing the divider up for each entry before sleep is applied.

// File: rtl/rc_pkg.sv
package rc_pkg;
    localparam int WORD_W = 32;
    localparam int DIV_W  = 15;
    localparam int SEL_W  = 4;

    localparam int B_ON    = 15;
    localparam int B_FRZ   = 14;
    localparam int B_SIDL  = 13;
    localparam int B_OE    = 12;
    localparam int B_RSLP  = 11;
    localparam int B_SW    = 9;
    localparam int B_ACT   = 8;
    localparam int DIV_LSB = 16;

    // Codes below this value ignore the run-in-sleep qualifier
    localparam logic [SEL_W-1:0] SEL_SLEEP_MIN = 4'd2;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_RUN,
        ST_HOLD,
        ST_STOP
    } rc_state_e;
endpackage

// File: rtl/rc_sync.sv
module rc_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rc_ctrl_regs.sv
module rc_ctrl_regs
    import rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic              active_s,
    input  logic              done_s,
    output logic              on_q,
    output logic              frz_q,
    output logic              sidl_q,
    output logic              oe_q,
    output logic              rslp_q,
    output logic              divsw_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [DIV_W-1:0]  div_q
);
    logic wr_ok;
    logic done_d;
    logic unused_wbits;

    // Writes only land while the request and its status agree
    assign wr_ok = wr_en && (on_q == active_s);
    assign unused_wbits = ^{wdata[31], wdata[10], wdata[B_ACT], wdata[7:4]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q    <= 1'b0;
            frz_q   <= 1'b0;
            sidl_q  <= 1'b0;
            oe_q    <= 1'b0;
            rslp_q  <= 1'b0;
            divsw_q <= 1'b0;
            sel_q   <= '0;
            div_q   <= '0;
            done_d  <= 1'b0;
        end else begin
            done_d <= done_s;
            if (wr_ok) begin
                div_q  <= wdata[DIV_LSB +: DIV_W];
                on_q   <= wdata[B_ON];
                frz_q  <= wdata[B_FRZ];
                sidl_q <= wdata[B_SIDL];
                oe_q   <= wdata[B_OE];
                rslp_q <= wdata[B_RSLP];
                if (!active_s) sel_q <= wdata[SEL_W-1:0];
            end
            if (done_s && !done_d)
                divsw_q <= 1'b0;
            else if (wr_ok && wdata[B_SW] && !done_s)
                divsw_q <= 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            rdata[DIV_LSB +: DIV_W] = div_q;
            rdata[B_ON]             = on_q;
            rdata[B_FRZ]            = frz_q;
            rdata[B_SIDL]           = sidl_q;
            rdata[B_OE]             = oe_q;
            rdata[B_RSLP]           = rslp_q;
            rdata[B_SW]             = divsw_q;
            rdata[B_ACT]            = active_s;
            rdata[SEL_W-1:0]        = sel_q;
        end
    end
endmodule

// File: rtl/rc_div_fsm.sv
module rc_div_fsm
    import rc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_s,
    input  logic             req_s,
    input  logic             frz,
    input  logic             sidl,
    input  logic             rslp,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div_field,
    input  logic             dbg_i,
    input  logic             idle_i,
    input  logic             sleep_i,
    output logic             ref_q,
    output logic             run_o,
    output logic             bypass_o,
    output logic             active_o,
    output logic             done_o,
    output rc_state_e        st_o,
    output logic [DIV_W-1:0] cnt_o,
    output logic [DIV_W-1:0] cur_div_o
);
    rc_state_e        st, st_nx;
    logic [DIV_W-1:0] cnt, cur_div;
    logic             freeze_req, stop_req, sleep_stop, load_pend, at_edge;

    assign freeze_req = frz && dbg_i;
    assign sleep_stop = sleep_i && (!rslp || (sel < SEL_SLEEP_MIN));
    assign stop_req   = (sidl && idle_i) || sleep_stop;
    assign load_pend  = req_s && !done_o;
    assign at_edge    = (cnt == cur_div - DIV_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OFF: if (on_s) st_nx = ST_RUN;
            ST_RUN, ST_HOLD, ST_STOP: begin
                if (!on_s)           st_nx = ST_OFF;
                else if (freeze_req) st_nx = ST_HOLD;
                else if (stop_req)   st_nx = ST_STOP;
                else                 st_nx = ST_RUN;
            end
            default: st_nx = ST_OFF;
        endcase
    end

    // Divider datapath and status, driven by the current state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            cur_div  <= '0;
            ref_q    <= 1'b0;
            done_o   <= 1'b0;
            active_o <= 1'b0;
        end else begin
            active_o <= (st != ST_OFF);
            unique case (st)
                ST_OFF: begin
                    cnt     <= '0;
                    ref_q   <= 1'b0;
                    cur_div <= div_field;
                    if (load_pend) done_o <= 1'b1;
                end
                ST_RUN: begin
                    if (cur_div == '0) begin
                        cnt   <= '0;
                        ref_q <= 1'b0;
                        if (load_pend) begin
                            cur_div <= div_field;
                            done_o  <= 1'b1;
                        end
                    end else if (at_edge) begin
                        cnt   <= '0;
                        ref_q <= ~ref_q;
                        if (load_pend) begin
                            cur_div <= div_field;
                            done_o  <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + DIV_W'(1);
                    end
                end
                ST_HOLD: begin
                    cnt   <= cnt;
                    ref_q <= ref_q;
                end
                ST_STOP: begin
                    cnt   <= '0;
                    ref_q <= 1'b0;
                    if (load_pend) begin
                        cur_div <= div_field;
                        done_o  <= 1'b1;
                    end
                end
                default: begin
                    cnt   <= '0;
                    ref_q <= 1'b0;
                end
            endcase
            if (!req_s) done_o <= 1'b0;
        end
    end

    assign run_o     = (st == ST_RUN);
    assign bypass_o  = (cur_div == '0);
    assign st_o      = st;
    assign cnt_o     = cnt;
    assign cur_div_o = cur_div;
endmodule

// File: rtl/rc_refgen.sv
module rc_refgen
    import rc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        bus_clk,
    input  logic        bus_rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        base_clk,
    input  logic        base_rst_n,
    input  logic        dbg_i,
    input  logic        idle_i,
    input  logic        sleep_i,
    output logic        ref_clk_o,
    output logic        ref_pin_o,
    output logic [3:0]  sel_o
);
    logic             on_q, frz_q, sidl_q, oe_q, rslp_q, divsw_q;
    logic [SEL_W-1:0] sel_q;
    logic [DIV_W-1:0] div_field;
    logic             on_s, req_s, active_b, done_b, active_s, done_s;
    logic             ref_q, run, bypass;
    rc_state_e        st;
    logic [DIV_W-1:0] cnt, cur_div;

    rc_ctrl_regs u_regs (
        .clk      (bus_clk),
        .rst_n    (bus_rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .wdata    (wdata),
        .rdata    (rdata),
        .active_s (active_s),
        .done_s   (done_s),
        .on_q     (on_q),
        .frz_q    (frz_q),
        .sidl_q   (sidl_q),
        .oe_q     (oe_q),
        .rslp_q   (rslp_q),
        .divsw_q  (divsw_q),
        .sel_q    (sel_q),
        .div_q    (div_field)
    );

    rc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_to_base (
        .clk   (base_clk),
        .rst_n (base_rst_n),
        .d     ({on_q, divsw_q}),
        .q     ({on_s, req_s})
    );

    rc_sync #(.STAGES(SYNC_STAGES), .W(2)) u_to_bus (
        .clk   (bus_clk),
        .rst_n (bus_rst_n),
        .d     ({active_b, done_b}),
        .q     ({active_s, done_s})
    );

    rc_div_fsm u_div (
        .clk       (base_clk),
        .rst_n     (base_rst_n),
        .on_s      (on_s),
        .req_s     (req_s),
        .frz       (frz_q),
        .sidl      (sidl_q),
        .rslp      (rslp_q),
        .sel       (sel_q),
        .div_field (div_field),
        .dbg_i     (dbg_i),
        .idle_i    (idle_i),
        .sleep_i   (sleep_i),
        .ref_q     (ref_q),
        .run_o     (run),
        .bypass_o  (bypass),
        .active_o  (active_b),
        .done_o    (done_b),
        .st_o      (st),
        .cnt_o     (cnt),
        .cur_div_o (cur_div)
    );

    assign ref_clk_o = bypass ? (base_clk & run) : ref_q;
    assign ref_pin_o = ref_clk_o & oe_q;
    assign sel_o     = sel_q;
endmodule

// File: rtl/rc_refgen_chk.sv
module rc_refgen_chk
    import rc_pkg::*;
(
    input logic             bus_clk,
    input logic             bus_rst_n,
    input logic             base_clk,
    input logic             base_rst_n,
    input logic             wr_en,
    input logic             on_q,
    input logic             active_s,
    input logic             done_s,
    input logic             divsw_q,
    input logic [SEL_W-1:0] sel_q,
    input logic [DIV_W-1:0] div_field,
    input rc_state_e        st,
    input logic [DIV_W-1:0] cnt,
    input logic [DIV_W-1:0] cur_div,
    input logic             ref_q
);
    p_cnt_bound_r2: assert property (@(posedge base_clk) disable iff (!base_rst_n)
        (cur_div != '0) |-> (cnt < cur_div));

    p_active_rise_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(active_s) |-> on_q);

    p_divsw_clear_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $fell(divsw_q) |-> done_s);

    p_hold_r6: assert property (@(posedge base_clk) disable iff (!base_rst_n)
        (st == ST_HOLD && $past(st) == ST_HOLD) |-> ($stable(cnt) && $stable(ref_q)));

    p_stop_low_r7: assert property (@(posedge base_clk) disable iff (!base_rst_n)
        (st == ST_STOP && $past(st) == ST_STOP) |-> !ref_q);

    p_sel_locked_r10: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        (active_s && $past(active_s)) |-> $stable(sel_q));

    p_wr_ignored_r11: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $past(wr_en && (on_q != active_s)) |-> ($stable(on_q) && $stable(div_field)));
endmodule

bind rc_refgen rc_refgen_chk u_chk (
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .base_clk   (base_clk),
    .base_rst_n (base_rst_n),
    .wr_en      (wr_en),
    .on_q       (on_q),
    .active_s   (active_s),
    .done_s     (done_s),
    .divsw_q    (divsw_q),
    .sel_q      (sel_q),
    .div_field  (div_field),
    .st         (st),
    .cnt        (cnt),
    .cur_div    (cur_div),
    .ref_q      (ref_q)
);

// File: tb/sim_rc_refgen.sv
module sim_rc_refgen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic        dbg_i = 1'b0, idle_i = 1'b0, sleep_i = 1'b0;
    logic        ref_clk_o, ref_pin_o;
    logic [3:0]  sel_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    logic       c_frz = 0, c_sidl = 0, c_oe = 0, c_rslp = 0;
    logic [3:0] c_sel = '0;

    // Sleep table: {source code, RSLP, output expected to keep running}
    localparam logic [5:0] SLP_TAB [16] = '{
        {4'd0, 1'b0, 1'b0}, {4'd0, 1'b1, 1'b0}, {4'd1, 1'b0, 1'b0}, {4'd1, 1'b1, 1'b0},
        {4'd2, 1'b0, 1'b0}, {4'd2, 1'b1, 1'b1}, {4'd3, 1'b1, 1'b1}, {4'd4, 1'b1, 1'b1},
        {4'd5, 1'b0, 1'b0}, {4'd6, 1'b1, 1'b1}, {4'd7, 1'b1, 1'b1}, {4'd8, 1'b1, 1'b1},
        {4'd9, 1'b1, 1'b1}, {4'd10, 1'b0, 1'b0}, {4'd10, 1'b1, 1'b1}, {4'd11, 1'b1, 1'b1}
    };

    always #5 clk = ~clk;

    rc_refgen u0 (
        .bus_clk(clk), .bus_rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .base_clk(clk), .base_rst_n(rst_n),
        .dbg_i(dbg_i), .idle_i(idle_i), .sleep_i(sleep_i),
        .ref_clk_o(ref_clk_o), .ref_pin_o(ref_pin_o), .sel_o(sel_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [14:0] d, input logic on, input logic sw);
        mk = {1'b0, d, on, c_frz, c_sidl, c_oe, c_rslp, 1'b0, sw, 1'b0, 4'b0, c_sel};
    endfunction

    task automatic wr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wdata = v;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; #1; v = rdata; #1; rd_en = 1'b0;
    endtask

    task automatic wait_bit(input int b, input logic want, output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int i = 0; i < 70000; i++) begin
            rd(v);
            if (v[b] == want) begin ok = 1'b1; break; end
        end
    endtask

    task automatic measure(output int hi, output int lo);
        logic prev, cur;
        hi = 0; lo = 0;
        @(negedge clk); #1; prev = ref_clk_o;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk); #1; cur = ref_clk_o;
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk); #1;
            if (ref_clk_o) hi++; else break;
        end
        lo = 1;
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk); #1;
            if (!ref_clk_o) lo++; else break;
        end
    endtask

    task automatic toggles(input int n, output int t);
        logic prev;
        t = 0;
        @(negedge clk); #1; prev = ref_clk_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            if (ref_clk_o != prev) t++;
            prev = ref_clk_o;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1..R11 actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int hi, lo, t;
        int runs[16];
        int nr, len;
        logic prev, cur, ref0, same;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(v);
        chk(v == 32'h0, "R1 reset word", v, 0);
        chk(ref_clk_o == 1'b0 && ref_pin_o == 1'b0 && sel_o == 4'd0, "R1 reset outputs",
            {ref_clk_o, ref_pin_o, sel_o}, 0);

        // R4 ACTIVE is read-only
        wr(32'h0000_0100);
        repeat (10) @(negedge clk);
        rd(v);
        chk(v == 32'h0, "R4 write to status bit ignored", v, 0);

        // R1 field layout, reserved bits read 0
        wr(32'hFFFF_FFFF);
        rd(v);
        chk(v == 32'h7FFF_FA0F, "R1 all-ones readback", v, 32'h7FFF_FA0F);
        wait_bit(8, 1'b1, ok);
        repeat (20) @(negedge clk);
        rd(v);
        chk(v == 32'h7FFF_F90F, "R1 R4 active, switch done", v, 32'h7FFF_F90F);
        wr(32'h0);
        wait_bit(8, 1'b0, ok);
        chk(ok, "R4 ACTIVE falls after off", ok, 1);

        // R11 writes ignored while ON and ACTIVE differ
        c_sel = 4'd3;
        wr(mk(15'd1, 1'b0, 1'b0));
        wr(mk(15'd1, 1'b1, 1'b0));
        wr(mk(15'd9, 1'b1, 1'b0));
        rd(v);
        chk(v[30:16] == 15'd1, "R11 write during mismatch ignored", v[30:16], 1);
        chk(v[8] == 1'b0, "R4 ACTIVE lags ON", v[8], 0);
        wait_bit(8, 1'b1, ok);
        chk(ok, "R4 ACTIVE follows ON", ok, 1);

        // R2 N=1
        measure(hi, lo);
        chk(hi == 1 && lo == 1, "R2 N=1 phases", {hi[15:0], lo[15:0]}, {16'd1, 16'd1});

        // R10 source locked while active
        c_sel = 4'd7;
        wr(mk(15'd1, 1'b1, 1'b0));
        rd(v);
        chk(v[3:0] == 4'd3 && sel_o == 4'd3, "R10 select write ignored while active",
            {v[3:0], sel_o}, {4'd3, 4'd3});
        c_sel = 4'd3;

        // R5 switch to 2
        wr(mk(15'd2, 1'b1, 1'b1));
        rd(v);
        chk(v[9] == 1'b1, "R5 switch busy after request", v[9], 1);
        wait_bit(9, 1'b0, ok);
        chk(ok, "R5 switch busy clears", ok, 1);
        measure(hi, lo);
        chk(hi == 2 && lo == 2, "R2 N=2 phases", {hi[15:0], lo[15:0]}, {16'd2, 16'd2});

        // R5 mid-run switch 2 -> 3 without runts
        wr(mk(15'd3, 1'b1, 1'b1));
        nr = 0; len = 1;
        @(negedge clk); #1; prev = ref_clk_o;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); #1; cur = ref_clk_o;
            if (cur == prev) len++;
            else begin
                if (nr < 16) begin runs[nr] = len; nr++; end
                len = 1; prev = cur;
            end
        end
        ok = (nr >= 4);
        for (int i = 1; i < nr; i++) if (runs[i] != 2 && runs[i] != 3) ok = 1'b0;
        chk(ok, "R5 phases during switch are 2 or 3", nr, 4);
        chk(nr >= 2 && runs[nr-1] == 3, "R5 new divisor in effect", runs[nr-1], 3);
        wait_bit(9, 1'b0, ok);
        chk(ok, "R5 busy cleared after switch", ok, 1);
        measure(hi, lo);
        chk(hi == 3 && lo == 3, "R2 N=3 phases", {hi[15:0], lo[15:0]}, {16'd3, 16'd3});

        // R9 pin gating
        toggles(10, t);
        ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1; if (ref_pin_o) ok = 1'b0;
        end
        chk(ok && t > 0, "R9 pin low with OE=0", t, 1);
        c_oe = 1'b1;
        wr(mk(15'd3, 1'b1, 1'b0));
        ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); #1; if (ref_pin_o != ref_clk_o) ok = 1'b0;
        end
        chk(ok, "R9 pin follows clock with OE=1", ok, 1);

        // R3 bypass
        wr(mk(15'd0, 1'b1, 1'b1));
        wait_bit(9, 1'b0, ok);
        repeat (3) @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #2; if (!ref_clk_o) ok = 1'b0;
            @(negedge clk); #2; if (ref_clk_o) ok = 1'b0;
        end
        chk(ok, "R3 N=0 passes base clock", ok, 1);

        // R6 freeze
        c_frz = 1'b1;
        wr(mk(15'd4, 1'b1, 1'b1));
        wait_bit(9, 1'b0, ok);
        repeat (5) @(negedge clk);
        dbg_i = 1'b1;
        repeat (2) @(negedge clk);
        #1; ref0 = ref_clk_o; same = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1; if (ref_clk_o != ref0) same = 1'b0;
        end
        chk(same, "R6 frozen output holds", same, 1);
        dbg_i = 1'b0;
        measure(hi, lo);
        chk(hi == 4 && lo == 4, "R6 resumes N=4", {hi[15:0], lo[15:0]}, {16'd4, 16'd4});
        c_frz = 1'b0;
        wr(mk(15'd4, 1'b1, 1'b0));
        dbg_i = 1'b1;
        measure(hi, lo);
        chk(hi == 4 && lo == 4, "R6 debug ignored with FRZ=0", {hi[15:0], lo[15:0]}, {16'd4, 16'd4});
        dbg_i = 1'b0;

        // R7 idle
        c_sidl = 1'b1;
        wr(mk(15'd4, 1'b1, 1'b0));
        idle_i = 1'b1;
        repeat (3) @(negedge clk);
        ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); #1; if (ref_clk_o) ok = 1'b0;
        end
        chk(ok, "R7 idle stops output low", ok, 1);
        c_sidl = 1'b0;
        wr(mk(15'd4, 1'b1, 1'b0));
        measure(hi, lo);
        chk(hi == 4 && lo == 4, "R7 idle ignored with SIDL=0", {hi[15:0], lo[15:0]}, {16'd4, 16'd4});
        idle_i = 1'b0;

        wr(mk(15'd4, 1'b0, 1'b0));
        wait_bit(8, 1'b0, ok);

        // R8 sleep table
        foreach (SLP_TAB[k]) begin
            c_sel  = SLP_TAB[k][5:2];
            c_rslp = SLP_TAB[k][1];
            wr(mk(15'd1, 1'b0, 1'b0));
            wr(mk(15'd1, 1'b1, 1'b0));
            wait_bit(8, 1'b1, ok);
            sleep_i = 1'b1;
            repeat (4) @(negedge clk);
            toggles(8, t);
            if (SLP_TAB[k][0])
                chk(t > 0, $sformatf("R8 sel=%0d rslp=%0d keeps running", c_sel, c_rslp), t, 8);
            else
                chk(t == 0 && !ref_clk_o, $sformatf("R8 sel=%0d rslp=%0d stops", c_sel, c_rslp), t, 0);
            sleep_i = 1'b0;
            wr(mk(15'd1, 1'b0, 1'b0));
            wait_bit(8, 1'b0, ok);
        end

        // R2 largest divisor
        c_sel = 4'd2; c_rslp = 1'b0;
        wr(mk(15'h7FFF, 1'b0, 1'b0));
        wr(mk(15'h7FFF, 1'b1, 1'b0));
        measure(hi, lo);
        chk(hi == 32767 && lo == 32767, "R2 N=32767 phases", {hi[15:0], lo[15:0]},
            {16'd32767, 16'd32767});

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule